// File: doc/BRIEF.md
# Mode-Configurable Sum-of-Products Macrocell Array

This block models the logic core of a twenty-pin programmable sum-of-products device with eight output macrocells. An AND array, defined by a flat fuse vector, forms product terms from eight dedicated inputs and eight feedback slots, each in true and complemented form. Every macrocell ORs its group of product terms, applies a programmable polarity, and drives its pad either directly or through a register. Its output enable comes from a shared pin, from a product term, or is tied off.

A two-bit global mode picks one of three operating styles. In registered style the first special pin (`pin_clk`) clocks every register and the second (`oe_pin_n`) gates the registered outputs. In complex and simple styles both special pins become array inputs through the outer feedback slots, and the registers are unused. Per-cell bits choose registered operation, dedicated-input operation and output polarity. The pads are split into a value, an enable and an observed level, so the surrounding logic resolves the bidirectional pin.

Top module: `pal_macro_array`

## Requirements
- R1: Product term p is the AND of every literal whose fuse bit `cfg_fuse[p*32 + 2j]` (true form of signal j) or `cfg_fuse[p*32 + 2j + 1]` (complement of signal j) is 1. Signals 0 to 7 are `pin_in[0..7]` and signals 8 to 15 are feedback slots 0 to 7. A term with no fuse set evaluates to 0.
- R2: Cell c owns terms 8c to 8c+7. When the cell takes a term as its output enable, that term is 8c and the sum uses 8c+1 to 8c+7. Otherwise the sum uses all eight.
- R3: With `cfg_pol[c]`=1 the cell value equals its sum. With 0 it is the inverted sum.
- R4: `cfg_mode` 00 selects simple, 01 selects complex, and both 10 and 11 select registered.
- R5: In registered mode, a cell with `cfg_reg[c]`=1 and `cfg_inp[c]`=0 sums eight terms. Its pad shows the cell value captured at the last rising edge of `pin_clk`, and it is enabled exactly when `oe_pin_n` is 0. Its feedback slot carries that registered output.
- R6: In registered mode, any other cell is combinational: seven-term sum, term 8c as enable, and slot c carries `pad_in[c]`. Neither `pin_clk` nor `oe_pin_n` reaches the array.
- R7: A cell with `cfg_inp[c]`=1 never drives its pad (`pad_oe[c]`=0). Cells 3 and 4 in simple mode are the exception.
- R8: In complex mode every cell sums seven terms with term 8c as its enable. Slot 0 carries `oe_pin_n`, slot 7 carries `pin_clk`, and slots 1 to 6 carry their own `pad_in`. `cfg_reg` has no effect.
- R9: In simple mode every cell sums eight terms and is always enabled unless it is a dedicated input. Cells 3 and 4 are always enabled. Slot 0 carries `oe_pin_n` and slot 7 carries `pin_clk`. Slots 1 to 3 carry `pad_in` of the cell below, and slots 4 to 6 carry `pad_in` of the cell above.
- R10: While `rst_n` is 0 every register is cleared at once and held clear across clock edges, so registered pads read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_clk | input | 1 | Register clock in registered mode; array input otherwise |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| oe_pin_n | input | 1 | Active-low shared enable in registered mode; array input otherwise |
| pin_in | input | 8 | Dedicated array inputs |
| cfg_mode | input | 2 | Global operating mode |
| cfg_fuse | input | 2048 | AND-array fuse map, 64 terms of 32 columns |
| cfg_reg | input | 8 | Per-cell registered select |
| cfg_inp | input | 8 | Per-cell dedicated-input select |
| cfg_pol | input | 8 | Per-cell output polarity |
| pad_in | input | 8 | Observed level on each macrocell pin |
| pad_out | output | 8 | Value each macrocell drives |
| pad_oe | output | 8 | Drive enable for each macrocell pin |

## Verification
A corrupted register shows on its registered pad as soon as it is loaded. Because the registered output also feeds the array, the error spreads into other cells' sums by the next edge. A misrouted feedback slot or a wrong term split does not show as a wrong register. It shows as a wrong combinational pad value or enable in the same cycle, but only for input patterns that make the affected literal decide the term. For that reason every mode is swept over many sparse fuse maps and random pin levels, and each result is checked in both clock phases, since `pin_clk` is itself an array input outside registered mode.

// File: rtl/pal_macro_array.sv
`timescale 1ns/1ps
module pal_macro_array #(
  parameter int N_CELLS = 8,
  parameter int N_IN    = 8,
  parameter int PTS     = 8
)(
  input  logic                                        pin_clk,
  input  logic                                        rst_n,
  input  logic                                        oe_pin_n,
  input  logic [N_IN-1:0]                             pin_in,
  input  logic [1:0]                                  cfg_mode,
  input  logic [N_CELLS*PTS*2*(N_IN+N_CELLS)-1:0]     cfg_fuse,
  input  logic [N_CELLS-1:0]                          cfg_reg,
  input  logic [N_CELLS-1:0]                          cfg_inp,
  input  logic [N_CELLS-1:0]                          cfg_pol,
  input  logic [N_CELLS-1:0]                          pad_in,
  output logic [N_CELLS-1:0]                          pad_out,
  output logic [N_CELLS-1:0]                          pad_oe
);
  localparam int NSIG = N_IN + N_CELLS;
  localparam int NCOL = 2 * NSIG;
  localparam int NPT  = N_CELLS * PTS;
  localparam int MID  = N_CELLS / 2;

  logic is_reg, is_simp;
  logic [N_CELLS-1:0] q, fb, yv, rcv;
  logic [NSIG-1:0] sig;
  logic [NCOL-1:0] col;
  logic [NPT-1:0]  pt;

  assign is_reg  = cfg_mode[1];
  assign is_simp = (cfg_mode == 2'b00);
  assign sig     = {fb, pin_in};

  genvar j, p, c;
  for (j = 0; j < NSIG; j++) begin : g_col
    assign col[2*j]   = sig[j];
    assign col[2*j+1] = ~sig[j];
  end

  for (p = 0; p < NPT; p++) begin : g_pt
    logic [NCOL-1:0] row;
    assign row   = cfg_fuse[p*NCOL +: NCOL];
    assign pt[p] = (|row) & (&(col | ~row));
  end

  for (c = 0; c < N_CELLS; c++) begin : g_cell
    logic [PTS-1:0] t;
    logic s, inp, alt;
    assign t      = pt[c*PTS +: PTS];
    assign rcv[c] = is_reg & cfg_reg[c] & ~cfg_inp[c];
    assign s      = (is_simp | rcv[c]) ? (|t) : (|t[PTS-1:1]);
    assign yv[c]  = cfg_pol[c] ? s : ~s;

    if (c == MID - 1 || c == MID) begin : g_mid
      assign inp = cfg_inp[c] & ~is_simp;
    end else begin : g_side
      assign inp = cfg_inp[c];
    end

    if (c == 0) begin : g_fb_lo
      assign alt = oe_pin_n;
    end else if (c == N_CELLS - 1) begin : g_fb_hi
      assign alt = pin_clk;
    end else if (c < MID) begin : g_fb_low_half
      assign alt = is_simp ? pad_in[c-1] : pad_in[c];
    end else begin : g_fb_high_half
      assign alt = is_simp ? pad_in[c+1] : pad_in[c];
    end

    assign fb[c]      = is_reg ? (rcv[c] ? ~q[c] : pad_in[c]) : alt;
    assign pad_out[c] = rcv[c] ? ~q[c] : yv[c];
    assign pad_oe[c]  = inp ? 1'b0 : rcv[c] ? ~oe_pin_n : is_simp ? 1'b1 : t[0];

    AST_INPUT_CELL_OFF: assert property (@(posedge pin_clk) disable iff (!rst_n) (cfg_inp[c] && !(is_simp && (c == MID - 1 || c == MID))) |-> !pad_oe[c]); // R7
    AST_REG_OE_PIN: assert property (@(posedge pin_clk) disable iff (!rst_n) rcv[c] |-> (pad_oe[c] == !oe_pin_n)); // R5
    AST_REG_CAPTURE: assert property (@(posedge pin_clk) disable iff (!rst_n) ($past(rst_n) && $past(rcv[c]) && rcv[c]) |-> (pad_out[c] == $past(yv[c]))); // R5
    AST_SIMPLE_DRIVEN: assert property (@(posedge pin_clk) disable iff (!rst_n) (is_simp && !inp) |-> pad_oe[c]); // R9
  end

  always_ff @(posedge pin_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~rcv) | (~yv & rcv);
  end

  AST_CENTRE_DRIVEN: assert property (@(posedge pin_clk) disable iff (!rst_n) is_simp |-> (pad_oe[MID] && pad_oe[MID-1])); // R9
endmodule

// File: tb/pal_macro_array_bench.sv
`timescale 1ns/1ps
module pal_macro_array_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, oe_n;
  logic [7:0]  pin_in, pad_in, creg, cinp, cpol, pad_out, pad_oe;
  logic [1:0]  mode;
  logic [2047:0] fuse;
  logic [7:0]  q_m = '0;
  int checks = 0;
  int errors = 0;

  pal_macro_array u_pal_macro_array (
    .pin_clk(clk), .rst_n(rst_n), .oe_pin_n(oe_n), .pin_in(pin_in),
    .cfg_mode(mode), .cfg_fuse(fuse), .cfg_reg(creg), .cfg_inp(cinp),
    .cfg_pol(cpol), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic model(output logic [7:0] eo, output logic [7:0] eoe,
                       output logic [7:0] ey, output logic [7:0] erc);
    logic [15:0] sv;
    logic [63:0] ptv;
    logic [7:0]  fbv;
    for (int k = 0; k < 8; k++) begin
      erc[k] = mode[1] && creg[k] && !cinp[k];
      if (mode[1])             fbv[k] = erc[k] ? ~q_m[k] : pad_in[k];
      else if (k == 0)         fbv[k] = oe_n;
      else if (k == 7)         fbv[k] = clk;
      else if (mode == 2'b01)  fbv[k] = pad_in[k];
      else if (k < 4)          fbv[k] = pad_in[k-1];
      else                     fbv[k] = pad_in[k+1];
    end
    sv = {fbv, pin_in};
    for (int p = 0; p < 64; p++) begin
      logic any, all;
      any = 1'b0; all = 1'b1;
      for (int cl = 0; cl < 32; cl++)
        if (fuse[p*32+cl]) begin
          any = 1'b1;
          all = all & ((cl % 2 == 0) ? sv[cl/2] : ~sv[cl/2]);
        end
      ptv[p] = any & all;
    end
    for (int c = 0; c < 8; c++) begin
      logic s, din;
      s = (mode == 2'b00 || erc[c]) ? (|ptv[c*8 +: 8]) : (|ptv[c*8+1 +: 7]);
      ey[c] = cpol[c] ? s : ~s;
      eo[c] = erc[c] ? ~q_m[c] : ey[c];
      din = cinp[c] && !(mode == 2'b00 && (c == 3 || c == 4));
      eoe[c] = din ? 1'b0 : erc[c] ? ~oe_n : (mode == 2'b00) ? 1'b1 : ptv[c*8];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] a, b, y, r;
    if (!rst_n) q_m <= '0;
    else begin
      model(a, b, y, r);
      for (int k = 0; k < 8; k++) if (r[k]) q_m[k] <= ~y[k];
    end
  end

  task automatic check_now(input string tag);
    logic [7:0] eo, eoe, ey, erc, m;
    model(eo, eoe, ey, erc);
    m = eoe | erc;
    checks++;
    if (pad_oe !== eoe) begin
      errors++;
      $display("FAIL %s pad_oe actual %b expected %b", tag, pad_oe, eoe);
    end
    checks++;
    if ((pad_out & m) !== (eo & m)) begin
      errors++;
      $display("FAIL %s pad_out actual %b expected %b (mask %b)", tag, pad_out & m, eo & m, m);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    pin_in = 8'($urandom); pad_in = 8'($urandom); oe_n = 1'($urandom);
    #1 check_now(tag);
    @(negedge clk); #1 check_now(tag);
  endtask

  task automatic new_cfg(input logic [1:0] md, input int kind);
    @(posedge clk); #1;
    mode = md;
    creg = 8'($urandom); cinp = 8'($urandom) & 8'($urandom); cpol = 8'($urandom);
    fuse = '0;
    if (kind == 0) cinp = 8'hFF;
    if (kind != 1)
      for (int p = 0; p < 64; p++) begin
        int n;
        n = (p % 8 == 0) ? int'($urandom % 3) : int'($urandom % 4);
        for (int i = 0; i < n; i++) fuse[p*32 + int'($urandom % 32)] = 1'b1;
      end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R10 watchdog actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b10; creg = 8'hFF; cinp = '0; cpol = 8'h5A;
    fuse = '0; oe_n = 1'b0; pin_in = '0; pad_in = '0;
    #1;
    checks++;
    if (pad_out !== 8'hFF) begin errors++; $display("FAIL R10 reset pad_out actual %b expected 11111111", pad_out); end
    checks++;
    if (pad_oe !== 8'hFF) begin errors++; $display("FAIL R10 reset pad_oe actual %b expected 11111111", pad_oe); end
    @(posedge clk); @(posedge clk); #1;
    fuse = '1; cpol = 8'hFF;
    @(posedge clk); #1;
    checks++;
    if (pad_out !== 8'hFF) begin errors++; $display("FAIL R10 held pad_out actual %b expected 11111111", pad_out); end
    @(negedge clk); rst_n = 1'b1;

    for (int md = 0; md < 4; md++)
      for (int k = 0; k < 8; k++) begin
        string tag;
        case (md)
          0: tag = "R9 R4 R1 R2 R3 R7";
          1: tag = "R8 R4 R1 R2 R3 R7";
          2: tag = "R5 R6 R1 R2 R3 R7";
          default: tag = "R4 R5 R6 R1 R2 R3";
        endcase
        new_cfg(2'(md), k);
        for (int s = 0; s < 40; s++) step(tag);
      end

    new_cfg(2'b10, 2);
    creg = 8'hFF; cinp = '0;
    for (int s = 0; s < 20; s++) step("R5");
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1 check_now("R10");
    checks++;
    if (pad_out !== 8'hFF) begin errors++; $display("FAIL R10 async pad_out actual %b expected 11111111", pad_out); end
    @(posedge clk); #1 check_now("R10");
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < 20; s++) step("R5 R10");

    summary();
    $finish;
  end
endmodule